// File: doc/BRIEF.md
# Graphics Extension Register Lock Block

This block holds the extension registers of a VGA-style graphics controller and the locks that guard them. A CPU reaches every register through an 8-bit index port and an 8-bit data port, with a 2-bit space select that picks the graphics-controller, sequencer or CRT-controller index space. Each space keeps its own index register. A data write goes to the register named by the current index of the selected space. A data read returns that register's byte one cycle later, together with a valid pulse.

Access is controlled in two independent ways. The first is a 3-bit key field in a lock/status register in the graphics space, which opens a window of extension registers. The second is a pair of read and write unlock flags that control the CRT-controller indices from 0x2A upward. Among those indices is a switch register whose upper nibble is taken from configuration straps while reset is held. Software can later overwrite that register, and three of its bits drive control outputs. One of those bits write-protects fixed fields of three standard registers.

The interface has no back-pressure. Every strobe is accepted in the cycle it is presented. A read request is answered exactly one cycle later, and the requester must capture the data in that cycle.

Top module: `gfx_ext_lock`

## Requirements
- R1: While rst_n is low (synchronous), the switch register loads {cfg_sw[3:0], 4'h0} with cfg_sw[3] in bit 7. The scratch, interlace start, interlace end and interlace mode registers, both CRT unlock flags, the key field, all three index registers, GR5, SR1 and SR3 all clear to zero.
- R2: Graphics-space indices 0x09 to 0x0E are extension registers. They can be read and written only while the key field equals 3'b101 (ext_unlocked high). Otherwise a read returns 8'hFF and a write changes nothing.
- R3: The lock/status register is at graphics index 0x0F and can always be accessed. A write stores data bits 2:0 as the key field. A read returns {cfg_md[3:0] latched in reset, cfg_md8 latched in reset, key[2:0]}.
- R4: CRT index 0x29 holds the unlock flags: bit 0 unlocks reads and bit 1 unlocks writes. It can always be accessed. A read at CRT index 0x2A or above returns 8'hFF while the read flag is clear.
- R5: A write at CRT index 0x2A or above is dropped while the write flag is clear.
- R6: The switch register is at CRT index 0x2A. A permitted write replaces all eight bits, including the strap nibble. A read returns the stored byte.
- R7: Switch bit 3 drives ega_on_analog. Switch bit 2 drives vclk2_cs_off. Switch bit 1 drives std_prot.
- R8: While std_prot is high, writes leave GR5 (graphics index 5) bits 6:5, SR1 (sequencer index 1) bits 5:2 and SR3 (sequencer index 3) bits 5:0 unchanged, and all other bits of those writes take effect.
- R9: While std_prot is low, writes to GR5, SR1 and SR3 replace all eight bits.
- R10: The cfg_sw, cfg_md and cfg_md8 pins are sampled only while reset is held. Changes on them after reset do not affect the register contents.
- R11: rd_valid is high in the cycle after a cycle with rd_req high and low otherwise. rd_data holds the addressed byte in that cycle. Unmapped indices and space select 3 read as 8'h00.
- R12: Scratch (0x2B), interlace start (0x2C), interlace end (0x2D) and the interlace mode flag (0x2E bit 0) store permitted writes, drive their outputs and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| bus_sel | input | 2 | Index space: 0 graphics, 1 sequencer, 2 CRT controller, 3 none |
| idx_we | input | 1 | Write wdata into the index register of the selected space |
| dat_we | input | 1 | Write wdata into the indexed register |
| rd_req | input | 1 | Read the indexed register |
| wdata | input | 8 | Write data for both index and data writes |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| cfg_sw | input | 4 | Straps loaded into switch bits 7:4 |
| cfg_md | input | 4 | Straps shown in lock/status bits 7:4 |
| cfg_md8 | input | 1 | Strap shown in lock/status bit 3 |
| ext_unlocked | output | 1 | Key field equals 3'b101 |
| gr5_q | output | 8 | Graphics register 5 |
| sr1_q | output | 8 | Sequencer register 1 |
| sr3_q | output | 8 | Sequencer register 3 |
| sw_q | output | 8 | Switch register |
| ega_on_analog | output | 1 | EGA emulation on analog display |
| vclk2_cs_off | output | 1 | Disable the external chip select of the second video clock |
| std_prot | output | 1 | Field protection of GR5/SR1/SR3 active |
| scratch_q | output | 8 | Scratch register |
| ilace_start_q | output | 8 | Interlace start |
| ilace_end_q | output | 8 | Interlace end |
| ilace_mode_q | output | 1 | Interlace mode flag |

## Verification
Most internal state of this block is visible directly at a port, so a wrong key, unlock flag or switch value appears on ext_unlocked, sw_q or the three control outputs in the cycle after the write that caused it. A wrongly gated write has no visible effect until that register is read or driven out. For this reason every blocked write is followed by a permitted read of the same index, and the value returned must be the old content, one cycle after the read request. A fault in the protect masks shows only in the particular bit positions concerned. The bench therefore writes both all-zero and all-one patterns over known contents.

// File: rtl/gfx_ext_pkg.sv
package gfx_ext_pkg;
  typedef enum logic [1:0] {
    SP_GC   = 2'd0,
    SP_SEQ  = 2'd1,
    SP_CRTC = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  localparam logic [7:0] GR5_IDX = 8'h05;
  localparam logic [7:0] SR1_IDX = 8'h01;
  localparam logic [7:0] SR3_IDX = 8'h03;

  // bits held when the protect bit is set
  localparam logic [7:0] GR5_PMASK = 8'h60;
  localparam logic [7:0] SR1_PMASK = 8'h3C;
  localparam logic [7:0] SR3_PMASK = 8'h3F;

  localparam logic [7:0] BLOCKED_RD = 8'hFF;
  localparam logic [7:0] UNMAPPED_RD = 8'h00;
endpackage

// File: rtl/gfx_ext_keyed.sv
module gfx_ext_keyed #(
  parameter int         EXT_NUM  = 6,
  parameter logic [7:0] EXT_BASE = 8'h09,
  parameter logic [7:0] LOCK_IDX = 8'h0F,
  parameter logic [2:0] KEY      = 3'b101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           cfg_md,
  input  logic                 cfg_md8,
  input  logic                 wr,
  input  logic [7:0]           idx,
  input  logic [7:0]           wdata,
  output logic                 unlocked,
  output logic [7:0]           status,
  output logic                 ext_hit,
  output logic [7:0]           ext_rd,
  output logic [EXT_NUM*8-1:0] ext_flat
);
  localparam logic [8:0] EXT_END = {1'b0, EXT_BASE} + 9'(EXT_NUM);

  logic [2:0] key_q;
  logic [3:0] md_q;
  logic       md8_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= 3'b000;
      md_q  <= cfg_md;
      md8_q <= cfg_md8;
    end else if (wr && idx == LOCK_IDX) begin
      key_q <= wdata[2:0];
    end
  end

  assign unlocked = (key_q == KEY);
  assign status   = {md_q, md8_q, key_q};
  assign ext_hit  = (idx >= EXT_BASE) && ({1'b0, idx} < EXT_END);

  for (genvar g = 0; g < EXT_NUM; g++) begin : g_ext
    localparam logic [7:0] MY_IDX = EXT_BASE + 8'(g);
    logic [7:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)                            r <= 8'h00;
      else if (wr && unlocked && idx == MY_IDX) r <= wdata;
    end
    assign ext_flat[g*8 +: 8] = r;
  end

  always_comb begin
    ext_rd = 8'h00;
    for (int i = 0; i < EXT_NUM; i++) begin
      if (idx == EXT_BASE + 8'(i)) ext_rd = ext_flat[i*8 +: 8];
    end
  end
endmodule

// File: rtl/gfx_ext_stdprot.sv
module gfx_ext_stdprot
  import gfx_ext_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gc_wr,
  input  logic       seq_wr,
  input  logic [7:0] gc_idx,
  input  logic [7:0] seq_idx,
  input  logic [7:0] wdata,
  input  logic       prot,
  output logic [7:0] gr5,
  output logic [7:0] sr1,
  output logic [7:0] sr3
);
  localparam int NREG = 3;
  localparam logic [NREG*8-1:0] PMASKS = {SR3_PMASK, SR1_PMASK, GR5_PMASK};

  logic [NREG-1:0]   hit;
  logic [NREG*8-1:0] q_flat;

  assign hit[0] = gc_wr  && gc_idx  == GR5_IDX;
  assign hit[1] = seq_wr && seq_idx == SR1_IDX;
  assign hit[2] = seq_wr && seq_idx == SR3_IDX;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] PM = PMASKS[g*8 +: 8];
    logic [7:0] keep;
    logic [7:0] r;
    assign keep = prot ? PM : 8'h00;
    always_ff @(posedge clk) begin
      if (!rst_n)      r <= 8'h00;
      else if (hit[g]) r <= (r & keep) | (wdata & ~keep);
    end
    assign q_flat[g*8 +: 8] = r;
  end

  assign gr5 = q_flat[7:0];
  assign sr1 = q_flat[15:8];
  assign sr3 = q_flat[23:16];
endmodule

// File: rtl/gfx_ext_crtc.sv
module gfx_ext_crtc
  import gfx_ext_pkg::*;
#(
  parameter logic [7:0] UNL_IDX  = 8'h29,
  parameter logic [7:0] EXT_BASE = 8'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  input  logic [3:0] cfg_sw,
  output logic       rd_unl,
  output logic       wr_unl,
  output logic [7:0] sw,
  output logic [7:0] scratch,
  output logic [7:0] ist,
  output logic [7:0] iend,
  output logic       imode,
  output logic [7:0] rd_byte
);
  localparam logic [7:0] SW_IDX  = EXT_BASE;
  localparam logic [7:0] SCR_IDX = EXT_BASE + 8'd1;
  localparam logic [7:0] IST_IDX = EXT_BASE + 8'd2;
  localparam logic [7:0] IEN_IDX = EXT_BASE + 8'd3;
  localparam logic [7:0] IMD_IDX = EXT_BASE + 8'd4;

  logic in_ext, wr_ok;
  assign in_ext = (idx >= EXT_BASE);
  assign wr_ok  = wr && in_ext && wr_unl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_unl  <= 1'b0;
      wr_unl  <= 1'b0;
      sw      <= {cfg_sw, 4'h0};
      scratch <= 8'h00;
      ist     <= 8'h00;
      iend    <= 8'h00;
      imode   <= 1'b0;
    end else begin
      if (wr && idx == UNL_IDX) begin
        rd_unl <= wdata[0];
        wr_unl <= wdata[1];
      end
      if (wr_ok) begin
        case (idx)
          SW_IDX:  sw      <= wdata;
          SCR_IDX: scratch <= wdata;
          IST_IDX: ist     <= wdata;
          IEN_IDX: iend    <= wdata;
          IMD_IDX: imode   <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_byte = UNMAPPED_RD;
    if (idx == UNL_IDX) begin
      rd_byte = {6'b0, wr_unl, rd_unl};
    end else if (in_ext) begin
      if (!rd_unl) rd_byte = BLOCKED_RD;
      else begin
        case (idx)
          SW_IDX:  rd_byte = sw;
          SCR_IDX: rd_byte = scratch;
          IST_IDX: rd_byte = ist;
          IEN_IDX: rd_byte = iend;
          IMD_IDX: rd_byte = {7'b0, imode};
          default: rd_byte = UNMAPPED_RD;
        endcase
      end
    end
  end
endmodule

// File: rtl/gfx_ext_lock.sv
module gfx_ext_lock
  import gfx_ext_pkg::*;
#(
  parameter int         EXT_NUM       = 6,
  parameter logic [7:0] EXT_BASE      = 8'h09,
  parameter logic [7:0] LOCK_IDX      = 8'h0F,
  parameter logic [7:0] CRTC_UNL_IDX  = 8'h29,
  parameter logic [7:0] CRTC_EXT_BASE = 8'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_sel,
  input  logic       idx_we,
  input  logic       dat_we,
  input  logic       rd_req,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  input  logic [3:0] cfg_sw,
  input  logic [3:0] cfg_md,
  input  logic       cfg_md8,
  output logic       ext_unlocked,
  output logic [7:0] gr5_q,
  output logic [7:0] sr1_q,
  output logic [7:0] sr3_q,
  output logic [7:0] sw_q,
  output logic       ega_on_analog,
  output logic       vclk2_cs_off,
  output logic       std_prot,
  output logic [7:0] scratch_q,
  output logic [7:0] ilace_start_q,
  output logic [7:0] ilace_end_q,
  output logic       ilace_mode_q
);
  space_e sel;
  assign sel = space_e'(bus_sel);

  logic [7:0] gc_idx, seq_idx, crtc_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gc_idx   <= 8'h00;
      seq_idx  <= 8'h00;
      crtc_idx <= 8'h00;
    end else if (idx_we) begin
      case (sel)
        SP_GC:   gc_idx   <= wdata;
        SP_SEQ:  seq_idx  <= wdata;
        SP_CRTC: crtc_idx <= wdata;
        default: ;
      endcase
    end
  end

  logic gc_wr, seq_wr, crtc_wr;
  assign gc_wr   = dat_we && sel == SP_GC;
  assign seq_wr  = dat_we && sel == SP_SEQ;
  assign crtc_wr = dat_we && sel == SP_CRTC;

  logic                 key_open, ext_hit;
  logic [7:0]           status, ext_rd, crtc_rd;
  logic [EXT_NUM*8-1:0] ext_flat;
  logic                 crtc_rd_unl, crtc_wr_unl;

  gfx_ext_keyed #(
    .EXT_NUM(EXT_NUM), .EXT_BASE(EXT_BASE), .LOCK_IDX(LOCK_IDX), .KEY(3'b101)
  ) u_keyed (
    .clk(clk), .rst_n(rst_n), .cfg_md(cfg_md), .cfg_md8(cfg_md8),
    .wr(gc_wr), .idx(gc_idx), .wdata(wdata),
    .unlocked(key_open), .status(status), .ext_hit(ext_hit),
    .ext_rd(ext_rd), .ext_flat(ext_flat)
  );

  gfx_ext_crtc #(
    .UNL_IDX(CRTC_UNL_IDX), .EXT_BASE(CRTC_EXT_BASE)
  ) u_crtc (
    .clk(clk), .rst_n(rst_n), .wr(crtc_wr), .idx(crtc_idx), .wdata(wdata),
    .cfg_sw(cfg_sw), .rd_unl(crtc_rd_unl), .wr_unl(crtc_wr_unl),
    .sw(sw_q), .scratch(scratch_q), .ist(ilace_start_q), .iend(ilace_end_q),
    .imode(ilace_mode_q), .rd_byte(crtc_rd)
  );

  assign ega_on_analog = sw_q[3];
  assign vclk2_cs_off  = sw_q[2];
  assign std_prot      = sw_q[1];
  assign ext_unlocked  = key_open;

  gfx_ext_stdprot u_std (
    .clk(clk), .rst_n(rst_n), .gc_wr(gc_wr), .seq_wr(seq_wr),
    .gc_idx(gc_idx), .seq_idx(seq_idx), .wdata(wdata), .prot(std_prot),
    .gr5(gr5_q), .sr1(sr1_q), .sr3(sr3_q)
  );

  logic [7:0] rd_next;
  always_comb begin
    rd_next = UNMAPPED_RD;
    case (sel)
      SP_GC: begin
        if (ext_hit)                rd_next = key_open ? ext_rd : BLOCKED_RD;
        else if (gc_idx == LOCK_IDX) rd_next = status;
        else if (gc_idx == GR5_IDX)  rd_next = gr5_q;
      end
      SP_SEQ: begin
        if (seq_idx == SR1_IDX)      rd_next = sr1_q;
        else if (seq_idx == SR3_IDX) rd_next = sr3_q;
      end
      SP_CRTC: rd_next = crtc_rd;
      default: rd_next = UNMAPPED_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/gfx_ext_lock_chk.sv
module gfx_ext_lock_chk #(
  parameter int EXT_NUM = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           bus_sel,
  input logic                 dat_we,
  input logic                 rd_req,
  input logic [7:0]           rd_data,
  input logic                 rd_valid,
  input logic [7:0]           seq_idx,
  input logic [7:0]           crtc_idx,
  input logic                 crtc_rd_unl,
  input logic                 crtc_wr_unl,
  input logic                 key_open,
  input logic [EXT_NUM*8-1:0] ext_flat,
  input logic [7:0]           sr1_q,
  input logic [7:0]           sw_q,
  input logic                 std_prot
);
  p_ext_wr_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && bus_sel == 2'd0 && !key_open) |=> $stable(ext_flat));

  p_crtc_rd_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_sel == 2'd2 && crtc_idx >= 8'h2A && !crtc_rd_unl) |=> rd_data == 8'hFF);

  p_crtc_wr_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && bus_sel == 2'd2 && crtc_idx >= 8'h2A && !crtc_wr_unl) |=> $stable(sw_q));

  p_sr1_field_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && bus_sel == 2'd1 && seq_idx == 8'h01 && std_prot)
      |=> sr1_q[5:2] == $past(sr1_q[5:2]));

  p_strap_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(sw_q));

  p_rvalid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_rvalid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
endmodule

bind gfx_ext_lock gfx_ext_lock_chk #(.EXT_NUM(EXT_NUM)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .dat_we(dat_we),
  .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
  .seq_idx(seq_idx), .crtc_idx(crtc_idx),
  .crtc_rd_unl(crtc_rd_unl), .crtc_wr_unl(crtc_wr_unl),
  .key_open(key_open), .ext_flat(ext_flat),
  .sr1_q(sr1_q), .sw_q(sw_q), .std_prot(std_prot)
);

// File: tb/gfx_ext_lock_tb.sv
module gfx_ext_lock_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       idx_we = 1'b0, dat_we = 1'b0, rd_req = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [3:0] cfg_sw = 4'hA, cfg_md = 4'h6;
  logic       cfg_md8 = 1'b1;
  logic       ext_unlocked, ega_on_analog, vclk2_cs_off, std_prot, ilace_mode_q;
  logic [7:0] gr5_q, sr1_q, sr3_q, sw_q, scratch_q, ilace_start_q, ilace_end_q;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  gfx_ext_lock u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .idx_we(idx_we),
    .dat_we(dat_we), .rd_req(rd_req), .wdata(wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .cfg_sw(cfg_sw), .cfg_md(cfg_md), .cfg_md8(cfg_md8),
    .ext_unlocked(ext_unlocked), .gr5_q(gr5_q), .sr1_q(sr1_q), .sr3_q(sr3_q),
    .sw_q(sw_q), .ega_on_analog(ega_on_analog), .vclk2_cs_off(vclk2_cs_off),
    .std_prot(std_prot), .scratch_q(scratch_q), .ilace_start_q(ilace_start_q),
    .ilace_end_q(ilace_end_q), .ilace_mode_q(ilace_mode_q)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic set_idx(input logic [1:0] s, input logic [7:0] i);
    bus_sel = s; idx_we = 1'b1; wdata = i;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] i, input logic [7:0] d);
    set_idx(s, i);
    dat_we = 1'b1; wdata = d;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] i,
                    output logic [7:0] d, output logic v);
    set_idx(s, i);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] s, input logic [7:0] i,
                        input logic [7:0] exp);
    logic [7:0] d; logic v;
    rd(s, i, d, v);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v;
    chk("R1 sw", sw_q, 8'hA0);
    chk("R1 scratch", scratch_q, 8'h00);
    chk("R1 ilace", {ilace_start_q | ilace_end_q}, 8'h00);
    chk("R1 mode/key", {6'b0, ilace_mode_q, ext_unlocked}, 8'h00);
    chk("R1 std", gr5_q | sr1_q | sr3_q, 8'h00);
    chk("R11 idle valid", {7'b0, rd_valid}, 8'h00);
    rd(2'd0, 8'h0F, d, v);
    chk("R3 status", d, 8'h68);
    chk("R11 valid", {7'b0, v}, 8'h01);
    @(negedge clk);
    chk("R11 valid drops", {7'b0, rd_valid}, 8'h00);
    rd_chk("R11 unmapped", 2'd1, 8'h07, 8'h00);
    rd_chk("R11 none space", 2'd3, 8'h00, 8'h00);
    rd_chk("R4 unlock reg reset", 2'd2, 8'h29, 8'h00);
  endtask

  task automatic t_strap_ignored();
    cfg_sw = 4'h5; cfg_md = 4'h0; cfg_md8 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 sw", sw_q, 8'hA0);
    rd_chk("R10 status", 2'd0, 8'h0F, 8'h68);
  endtask

  task automatic t_key();
    wr(2'd0, 8'h0A, 8'h5A);
    rd_chk("R2 locked read", 2'd0, 8'h0A, 8'hFF);
    wr(2'd0, 8'h0F, 8'h05);
    chk("R2 unlocked", {7'b0, ext_unlocked}, 8'h01);
    rd_chk("R2 locked write dropped", 2'd0, 8'h0A, 8'h00);
    wr(2'd0, 8'h0A, 8'h5A);
    wr(2'd0, 8'h0E, 8'hC3);
    rd_chk("R2 ext 0A", 2'd0, 8'h0A, 8'h5A);
    rd_chk("R2 ext 0E", 2'd0, 8'h0E, 8'hC3);
    wr(2'd0, 8'h0F, 8'h03);
    chk("R3 relock", {7'b0, ext_unlocked}, 8'h00);
    rd_chk("R3 status key", 2'd0, 8'h0F, 8'h6B);
    rd_chk("R2 relocked read", 2'd0, 8'h0A, 8'hFF);
    wr(2'd0, 8'h0A, 8'h11);
    wr(2'd0, 8'h0F, 8'hFD);
    rd_chk("R3 status low bits", 2'd0, 8'h0F, 8'h6D);
    rd_chk("R2 reopened", 2'd0, 8'h0A, 8'h5A);
  endtask

  task automatic t_crtc_gate();
    rd_chk("R4 blocked read", 2'd2, 8'h2B, 8'hFF);
    rd_chk("R4 blocked sw", 2'd2, 8'h2A, 8'hFF);
    wr(2'd2, 8'h2B, 8'h33);
    wr(2'd2, 8'h2A, 8'h0E);
    chk("R5 sw held", sw_q, 8'hA0);
    wr(2'd2, 8'h29, 8'h01);
    rd_chk("R4 flags", 2'd2, 8'h29, 8'h01);
    rd_chk("R5 scratch dropped", 2'd2, 8'h2B, 8'h00);
    rd_chk("R6 sw strap", 2'd2, 8'h2A, 8'hA0);
    wr(2'd2, 8'h29, 8'h03);
    wr(2'd2, 8'h2B, 8'h33);
    rd_chk("R12 scratch", 2'd2, 8'h2B, 8'h33);
    chk("R12 scratch out", scratch_q, 8'h33);
  endtask

  task automatic t_switch();
    wr(2'd2, 8'h2A, 8'h0C);
    rd_chk("R6 sw replace", 2'd2, 8'h2A, 8'h0C);
    chk("R7 outs", {5'b0, ega_on_analog, vclk2_cs_off, std_prot}, 8'h06);
    wr(2'd2, 8'h2A, 8'hF2);
    chk("R7 outs2", {5'b0, ega_on_analog, vclk2_cs_off, std_prot}, 8'h01);
    wr(2'd2, 8'h2A, 8'h00);
  endtask

  task automatic t_protect();
    wr(2'd0, 8'h05, 8'hFF);
    wr(2'd1, 8'h01, 8'hFF);
    wr(2'd1, 8'h03, 8'hFF);
    rd_chk("R9 gr5", 2'd0, 8'h05, 8'hFF);
    rd_chk("R9 sr1", 2'd1, 8'h01, 8'hFF);
    rd_chk("R9 sr3", 2'd1, 8'h03, 8'hFF);
    wr(2'd2, 8'h2A, 8'h02);
    wr(2'd0, 8'h05, 8'h00);
    wr(2'd1, 8'h01, 8'h00);
    wr(2'd1, 8'h03, 8'h00);
    rd_chk("R8 gr5", 2'd0, 8'h05, 8'h60);
    rd_chk("R8 sr1", 2'd1, 8'h01, 8'h3C);
    rd_chk("R8 sr3", 2'd1, 8'h03, 8'h3F);
    wr(2'd1, 8'h03, 8'h80);
    chk("R8 sr3 upper", sr3_q, 8'hBF);
    wr(2'd2, 8'h2A, 8'h00);
    wr(2'd1, 8'h01, 8'h00);
    chk("R9 sr1 clear", sr1_q, 8'h00);
  endtask

  task automatic t_interlace();
    wr(2'd2, 8'h2C, 8'h12);
    wr(2'd2, 8'h2D, 8'h34);
    wr(2'd2, 8'h2E, 8'hFF);
    chk("R12 start", ilace_start_q, 8'h12);
    chk("R12 end", ilace_end_q, 8'h34);
    rd_chk("R12 mode rd", 2'd2, 8'h2E, 8'h01);
    rd_chk("R12 end rd", 2'd2, 8'h2D, 8'h34);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strap_ignored();
    t_key();
    t_crtc_gate();
    t_switch();
    t_protect();
    t_interlace();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule